// File: doc/BRIEF.md
# Two-Phase Synchronizable Digital PWM Engine

This block turns the duty word of one regulation loop into two gate-drive outputs for two interleaved power stages. A ramp counter advances once per system clock and sets the switching period. At each ramp rollover, the 16-bit fractional duty word is scaled by the period to give an on-time. Each phase then adds its own signed current-balance trim to that on-time. Phase A opens at ramp position zero. Phase B opens at a programmable offset and wraps around the period boundary when it has to.

The engine can be locked to other engines or to an outside timing source. A rising edge on the sync input restarts the ramp. The block gives out a one-clock sync pulse at one programmable ramp position and a converter sample trigger at another. A fault input blanks both gate outputs within the same cycle. Period, duty, trims and the phase-B offset are shadowed and take effect only at rollover, so a mid-period update cannot cut a pulse short. A four-register parallel write port holds the configuration. Edge placement resolution is one system clock.

Top module: `dpwm_engine`

## Requirements
- R1: The ramp counts 0, 1, … P-1 and then returns to 0, where P is the period register. A write of 0 or 1 to the period register stores 2. After reset P is 100.
- R2: The base on-time is floor(duty × P / 65536). The duty input is an unsigned fraction in which 0x0000 means 0.0 and 0xFFFF means just under 1.0.
- R3: The on-time of phase A is the base plus the signed two's-complement trim_a. The on-time of phase B is the base plus trim_b. Each sum is clamped to the range 0 to P.
- R4: gate_a is high while the ramp is below its on-time. gate_b is high for its on-time starting at ramp value equal to the offset register, wrapping modulo P. The offset resets to 50.
- R5: The period, duty, trims and offset in use change only at a ramp rollover. A period or duty update made mid-period leaves the current period unchanged.
- R6: A rising edge on sync_in sets the ramp to 0 at the next clock edge and starts a new period with freshly loaded settings. Holding sync_in high has no further effect.
- R7: sync_out is high for the cycle in which the ramp equals the sync threshold. adc_trig is high for the cycle in which the ramp equals the trigger threshold.
- R8: While fault is high, gate_a and gate_b are low within the same cycle, without waiting for a clock edge. The gates resume as soon as fault falls.
- R9: A write is taken at a clock edge with cfg_we high. cfg_addr selects the target: 0 period, 1 phase-B offset, 2 sync threshold, 3 trigger threshold.
- R10: After reset the gate outputs are low and both thresholds are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 12 | Configuration write value |
| duty_in | input | 16 | Fractional duty word from the compensator |
| trim_a | input | 8 | Signed balance trim for phase A |
| trim_b | input | 8 | Signed balance trim for phase B |
| sync_in | input | 1 | External ramp restart, rising-edge active |
| fault | input | 1 | Gate blanking request |
| gate_a | output | 1 | Phase A gate drive |
| gate_b | output | 1 | Phase B gate drive |
| sync_out | output | 1 | Ramp-position sync pulse |
| adc_trig | output | 1 | Ramp-position sample trigger |

## Verification
The corner cases are these:
- **Clamping at both ends.** The bench drives a near-full duty with a positive trim and a zero duty with a negative trim. A design that skipped the clamp would wrap the on-time and give a short pulse, or a pulse that never ends.
- **Phase B across the boundary.** An offset plus on-time that runs past the period must wrap. A design that did not wrap would lose the tail of the phase-B pulse.
- **Mid-period updates.** Period and duty change in the middle of a period. A design without shadow registers would end the current period early or change the pulse width at once.
- **Sync input.** A sync edge arrives mid-period and the input is then held high. A level-sensitive design would hold the ramp at zero.
- **Minimum period.** Writing a period below the minimum checks that the ramp cannot stall.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int CNT_W      = 12;
    localparam int DUTY_W     = 16;
    localparam int TRIM_W     = 8;
    localparam int MIN_PERIOD = 2;

    typedef logic [CNT_W-1:0]        cnt_t;
    typedef logic [DUTY_W-1:0]       duty_t;
    typedef logic signed [TRIM_W-1:0] trim_t;
    typedef logic [DUTY_W+CNT_W-1:0] prod_t;

    typedef enum logic [1:0] {
        CFG_PERIOD   = 2'd0,
        CFG_B_OFFSET = 2'd1,
        CFG_SYNC_THR = 2'd2,
        CFG_TRIG_THR = 2'd3
    } cfg_addr_e;

    typedef struct packed {
        cnt_t period;
        cnt_t b_offset;
        cnt_t sync_thr;
        cnt_t trig_thr;
    } cfg_t;

    typedef struct packed {
        cnt_t count;
        cnt_t period;
        logic wrap;
    } ramp_t;

    // Fractional duty times period, keeping the integer part.
    function automatic cnt_t scale_duty(duty_t duty, cnt_t period);
        prod_t prod;
        prod = prod_t'(duty) * prod_t'(period);
        return cnt_t'(prod >> DUTY_W);
    endfunction

    // Signed trim added to the base on-time, clamped to [0, period].
    function automatic cnt_t apply_trim(cnt_t base, trim_t trim, cnt_t period);
        logic signed [CNT_W+1:0] wide_base;
        logic signed [CNT_W+1:0] wide_trim;
        logic signed [CNT_W+1:0] wide_per;
        logic signed [CNT_W+1:0] sum;
        wide_base = $signed({2'b00, base});
        wide_trim = {{(CNT_W+2-TRIM_W){trim[TRIM_W-1]}}, trim};
        wide_per  = $signed({2'b00, period});
        sum       = wide_base + wide_trim;
        if (sum < 0)
            return '0;
        else if (sum > wide_per)
            return period;
        else
            return cnt_t'(sum);
    endfunction

    function automatic cnt_t floor_period(cnt_t value);
        return (value < cnt_t'(MIN_PERIOD)) ? cnt_t'(MIN_PERIOD) : value;
    endfunction

endpackage

// File: rtl/dpwm_cfg_regs.sv
module dpwm_cfg_regs
    import dpwm_pkg::*;
#(
    parameter int DEF_PERIOD = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  cnt_t        cfg_wdata,
    output cfg_t        cfg
);

    localparam cnt_t RST_PERIOD = cnt_t'(DEF_PERIOD);
    localparam cnt_t RST_OFFSET = cnt_t'(DEF_PERIOD / 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.period   <= RST_PERIOD;
            cfg.b_offset <= RST_OFFSET;
            cfg.sync_thr <= '0;
            cfg.trig_thr <= '0;
        end else if (cfg_we) begin
            case (cfg_addr_e'(cfg_addr))
                CFG_PERIOD:   cfg.period   <= floor_period(cfg_wdata);
                CFG_B_OFFSET: cfg.b_offset <= cfg_wdata;
                CFG_SYNC_THR: cfg.sync_thr <= cfg_wdata;
                CFG_TRIG_THR: cfg.trig_thr <= cfg_wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dpwm_ramp.sv
module dpwm_ramp
    import dpwm_pkg::*;
#(
    parameter int DEF_PERIOD = 100
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sync_in,
    input  cnt_t  period_next,
    input  cnt_t  sync_thr,
    input  cnt_t  trig_thr,
    output ramp_t ramp,
    output logic  sync_out,
    output logic  adc_trig
);

    localparam cnt_t RST_PERIOD = cnt_t'(DEF_PERIOD);

    logic sync_q;
    cnt_t count_q;
    cnt_t period_q;
    logic sync_rise;
    logic at_end;
    logic wrap;

    assign sync_rise = sync_in & ~sync_q;
    assign at_end    = (count_q >= (period_q - cnt_t'(1)));
    assign wrap      = sync_rise | at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= 1'b0;
            count_q  <= '0;
            period_q <= RST_PERIOD;
        end else begin
            sync_q <= sync_in;
            if (wrap) begin
                count_q  <= '0;
                period_q <= period_next;
            end else begin
                count_q  <= count_q + cnt_t'(1);
            end
        end
    end

    assign sync_out = (count_q == sync_thr);
    assign adc_trig = (count_q == trig_thr);

    assign ramp = '{count: count_q, period: period_q, wrap: wrap};

endmodule

// File: rtl/dpwm_phase.sv
module dpwm_phase
    import dpwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ramp_t ramp,
    input  cnt_t  period_next,
    input  duty_t duty,
    input  trim_t trim,
    input  cnt_t  start,
    output logic  gate,
    output cnt_t  on_time
);

    cnt_t on_q;
    cnt_t start_q;
    cnt_t rel;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q    <= '0;
            start_q <= '0;
        end else if (ramp.wrap) begin
            on_q    <= apply_trim(scale_duty(duty, period_next), trim, period_next);
            start_q <= start;
        end
    end

    always_comb begin
        if (ramp.count >= start_q)
            rel = ramp.count - start_q;
        else
            rel = ramp.count + ramp.period - start_q;
    end

    assign gate    = (rel < on_q);
    assign on_time = on_q;

endmodule

// File: rtl/dpwm_engine.sv
module dpwm_engine
    import dpwm_pkg::*;
#(
    parameter int DEF_PERIOD = 100
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_addr,
    input  logic [CNT_W-1:0]         cfg_wdata,
    input  logic [DUTY_W-1:0]        duty_in,
    input  logic signed [TRIM_W-1:0] trim_a,
    input  logic signed [TRIM_W-1:0] trim_b,
    input  logic                     sync_in,
    input  logic                     fault,
    output logic                     gate_a,
    output logic                     gate_b,
    output logic                     sync_out,
    output logic                     adc_trig
);

    localparam int NUM_PHASES = 2;

    cfg_t  cfg;
    ramp_t ramp;
    trim_t trim_arr  [NUM_PHASES];
    cnt_t  start_arr [NUM_PHASES];
    cnt_t  on_time   [NUM_PHASES];
    logic  gate_raw  [NUM_PHASES];

    cnt_t  ramp_count;
    cnt_t  ramp_period;
    logic  ramp_wrap;

    dpwm_cfg_regs #(.DEF_PERIOD(DEF_PERIOD)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    dpwm_ramp #(.DEF_PERIOD(DEF_PERIOD)) u_ramp (
        .clk         (clk),
        .rst         (rst),
        .sync_in     (sync_in),
        .period_next (cfg.period),
        .sync_thr    (cfg.sync_thr),
        .trig_thr    (cfg.trig_thr),
        .ramp        (ramp),
        .sync_out    (sync_out),
        .adc_trig    (adc_trig)
    );

    assign trim_arr[0]  = trim_a;
    assign trim_arr[1]  = trim_b;
    assign start_arr[0] = '0;
    assign start_arr[1] = cfg.b_offset;

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        dpwm_phase u_phase (
            .clk         (clk),
            .rst         (rst),
            .ramp        (ramp),
            .period_next (cfg.period),
            .duty        (duty_in),
            .trim        (trim_arr[p]),
            .start       (start_arr[p]),
            .gate        (gate_raw[p]),
            .on_time     (on_time[p])
        );
    end

    assign gate_a = gate_raw[0] & ~fault;
    assign gate_b = gate_raw[1] & ~fault;

    assign ramp_count  = ramp.count;
    assign ramp_period = ramp.period;
    assign ramp_wrap   = ramp.wrap;

endmodule

// File: rtl/dpwm_engine_chk.sv
module dpwm_engine_chk
    import dpwm_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic fault,
    input logic sync_in,
    input logic gate_a,
    input logic gate_b,
    input cnt_t count,
    input cnt_t period_act,
    input cnt_t on_a,
    input cnt_t on_b,
    input logic wrap
);

    AST_FAULT_BLANKS: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!gate_a && !gate_b)); // R8

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        count < period_act); // R1

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_in) |=> (count == '0)); // R6

    AST_ONTIME_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (on_a <= period_act) && (on_b <= period_act)); // R3

    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(period_act)); // R5

endmodule

bind dpwm_engine dpwm_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fault      (fault),
    .sync_in    (sync_in),
    .gate_a     (gate_a),
    .gate_b     (gate_b),
    .count      (ramp_count),
    .period_act (ramp_period),
    .on_a       (on_time[0]),
    .on_b       (on_time[1]),
    .wrap       (ramp_wrap)
);

// File: tb/sim_dpwm_engine.sv
`timescale 1ns/1ps
module sim_dpwm_engine;
    import dpwm_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    cnt_t cfg_wdata = '0;
    duty_t duty_in = '0;
    trim_t trim_a = '0;
    trim_t trim_b = '0;
    logic sync_in = 1'b0;
    logic fault = 1'b0;
    logic gate_a, gate_b, sync_out, adc_trig;

    always #2.5 clk = ~clk;

    dpwm_engine u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .duty_in(duty_in), .trim_a(trim_a),
        .trim_b(trim_b), .sync_in(sync_in), .fault(fault),
        .gate_a(gate_a), .gate_b(gate_b), .sync_out(sync_out), .adc_trig(adc_trig)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog R1 actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    typedef struct packed {
        int p; int duty; int ta; int tb; int off; int sthr;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{100, 32768,  0,  0,  50, 10},
        '{100, 16384,  5, -5,  50, 20},
        '{ 80, 65535, 10, -3,  40, 79},
        '{ 64,     0, -4,  3,  10,  0},
        '{ 50,  6553,  0,  0,  25, 49},
        '{120, 49152,  0,  0, 100,  5}
    };

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 2'(a);
        cfg_wdata = cnt_t'(d);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic wait_trig();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!adc_trig && n < 5000);
    endtask

    task automatic measure(output int len, output int a_hi, output int b_hi,
                           output int b_rise, output int s_idx);
        int i = 0;
        bit prev_b = 1'b1;
        a_hi = 0; b_hi = 0; b_rise = -1; s_idx = -1;
        do begin
            if (gate_a) a_hi++;
            if (gate_b) begin
                b_hi++;
                if (!prev_b && b_rise < 0) b_rise = i;
            end
            prev_b = gate_b;
            if (sync_out && s_idx < 0) s_idx = i;
            i++;
            @(negedge clk);
        end while (!adc_trig && i < 5000);
        len = i;
    endtask

    function automatic int exp_on(int duty, int p, int trim);
        int v;
        v = ((duty * p) >>> 16) + trim;
        if (v < 0) v = 0;
        if (v > p) v = p;
        return v;
    endfunction

    initial begin
        int len, a_hi, b_hi, b_rise, s_idx;
        int ea, eb;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk_eq("R10 gate_a after reset", int'(gate_a), 0);
        chk_eq("R10 gate_b after reset", int'(gate_b), 0);
        chk_eq("R10 sync_out at ramp 0 with threshold 0", int'(sync_out), 1);
        chk_eq("R10 adc_trig at ramp 0 with threshold 0", int'(adc_trig), 1);

        wait_trig();
        measure(len, a_hi, b_hi, b_rise, s_idx);
        chk_eq("R1 default period", len, 100);
        chk_eq("R2 zero duty phase A", a_hi, 0);

        duty_in = 16'h4000;
        wait_trig();
        wait_trig();
        measure(len, a_hi, b_hi, b_rise, s_idx);
        chk_eq("R4 default phase B offset", b_rise, 50);
        chk_eq("R2 quarter duty phase A", a_hi, 25);
        chk_eq("R2 quarter duty phase B", b_hi, 25);

        // Vector table: R2 R3 R4 R7 R9
        for (int v = 0; v < 6; v++) begin
            cfg_write(0, VECS[v].p);
            cfg_write(1, VECS[v].off);
            cfg_write(2, VECS[v].sthr);
            duty_in = duty_t'(VECS[v].duty);
            trim_a  = trim_t'(VECS[v].ta);
            trim_b  = trim_t'(VECS[v].tb);
            wait_trig();
            wait_trig();
            measure(len, a_hi, b_hi, b_rise, s_idx);
            ea = exp_on(VECS[v].duty, VECS[v].p, VECS[v].ta);
            eb = exp_on(VECS[v].duty, VECS[v].p, VECS[v].tb);
            chk_eq("R1 R9 period length", len, VECS[v].p);
            chk_eq("R3 phase A on-time", a_hi, ea);
            chk_eq("R3 phase B on-time", b_hi, eb);
            if (eb > 0 && eb < VECS[v].p)
                chk_eq("R4 phase B start", b_rise, VECS[v].off);
            chk_eq("R7 sync_out position", s_idx, VECS[v].sthr);
        end

        // Fault blanking: R8
        cfg_write(0, 100);
        cfg_write(1, 50);
        cfg_write(2, 10);
        duty_in = 16'h8000;
        trim_a = '0;
        trim_b = '0;
        wait_trig();
        wait_trig();
        chk_eq("R4 gate_a high at ramp 0", int'(gate_a), 1);
        fault = 1'b1;
        #1;
        chk_eq("R8 gate_a blanked at once", int'(gate_a), 0);
        repeat (60) @(negedge clk);
        chk_eq("R8 gate_b blanked while fault held", int'(gate_b), 0);
        fault = 1'b0;
        #1;
        chk_eq("R8 gate_b resumes after fault", int'(gate_b), 1);

        // Sync restart: R6
        wait_trig();
        repeat (30) @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        chk_eq("R6 ramp restarted by sync edge", int'(adc_trig), 1);
        measure(len, a_hi, b_hi, b_rise, s_idx);
        chk_eq("R6 held sync has no effect", len, 100);
        sync_in = 1'b0;

        // Shadowed update mid-period: R5
        wait_trig();
        cfg_write(0, 60);
        duty_in = 16'h2000;
        measure(len, a_hi, b_hi, b_rise, s_idx);
        chk_eq("R5 current period keeps old length", len, 98);
        chk_eq("R5 current period keeps old duty", a_hi, 48);
        measure(len, a_hi, b_hi, b_rise, s_idx);
        chk_eq("R5 new period length", len, 60);
        chk_eq("R5 R2 new duty on-time", a_hi, 7);

        // Trigger threshold position: R7
        cfg_write(0, 100);
        cfg_write(2, 20);
        cfg_write(3, 7);
        wait_trig();
        wait_trig();
        measure(len, a_hi, b_hi, b_rise, s_idx);
        chk_eq("R7 trigger spacing", len, 100);
        chk_eq("R7 sync_out relative to trigger", s_idx, 13);

        // Minimum period: R1
        cfg_write(3, 0);
        cfg_write(0, 1);
        wait_trig();
        wait_trig();
        measure(len, a_hi, b_hi, b_rise, s_idx);
        chk_eq("R1 period floor", len, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule